// File: doc/BRIEF.md
# Phase-Coherent Profiled Oscillator Bank

The block drives sixteen complex numerically controlled oscillators from a shared table of stored settings. Every oscillator owns thirty-two profile slots, and each slot holds a signed tuning word, an unsigned amplitude and a phase offset. A host loads the slots through a word-serial write port. A word sets the target location and the following data words fill it. A pulse command names one slot per oscillator. All oscillators move to their new slots on the same output sample.

The phase is not accumulated. For each sample it is computed as the tuning word times the number of samples since reset, plus the offset. The tone that a slot produces therefore depends only on that slot and the current time. Going back to a slot used earlier gives the same phase trajectory as if it had never been left. Each oscillator turns its phase into a cosine/sine pair taken from a computed table and scales the pair by its amplitude. All oscillators are then added with wrapping arithmetic into one I/Q stream.

Top module: `obank_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_i` and `out_q` are zero. Reset clears every oscillator's active setting to zero tuning word, zero amplitude and zero offset, and clears the sample counter n to zero.
- R2: A write with `wr_addr_sel`=1 is a location word. It enables the data writes that follow only if bit 15 equals the `CHAN_ID` parameter (default 0) and bit 14 is 1. When it does not enable them, every data write that follows is ignored until the next enabling location word.
- R3: The location word gives a 10-bit word pointer in bits 9:0. Bits 9:6 are the oscillator, bits 5:1 are the slot, and bit 0 picks the word (0 = tuning word, 1 = amplitude/offset word). Each accepted data write (`wr_addr_sel`=0) stores `wr_data` at the pointer and then adds one to the pointer, wrapping at 10 bits.
- R4: In the amplitude/offset word, bits 15:0 are the unsigned amplitude and bits 31:16 are the phase offset.
- R5: The pulse command has three 32-bit words. Bits 9:0 of word 0 are ignored. The 5-bit slot field of oscillator k sits at bits 10+5k of word 0 for k=0..3, at bits 5(k-4) of word 1 for k=4..9, and at bits 5(k-10) of word 2 for k=10..15.
- R6: When `cmd_stb` is sampled high, all sixteen oscillators latch their selected slots on that same edge. The output sample that leaves three edges later is the first one built entirely from the new selection.
- R7: Phase is ph = (n*ftw + offset*65536) mod 2^32, where n is the number of clock edges since reset released. It does not depend on which slots were active before.
- R8: The table index is ph[31:24]. The sine of index k is computed with m = k mod 128 and a = m*(128-m), as floor(32767*16*a / (81920 - 4*a)), negated when k >= 128. The cosine of k is the sine of (k+64) mod 256.
- R9: An oscillator outputs I = floor(cos*amp/65536) and Q = floor(sin*amp/65536), as 16-bit signed values.
- R10: `out_i`/`out_q` are the 16-bit wrapping (non-saturating) sums of all oscillator I/Q values.
- R11: Writing profile memory leaves the latched active settings unchanged. The output changes only after a later pulse command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host write strobe |
| wr_addr_sel | input | 1 | 1 = location word, 0 = data word |
| wr_data | input | 32 | Host write word |
| cmd_stb | input | 1 | Pulse command strobe |
| cmd_word0 | input | 32 | Pulse command word 0 |
| cmd_word1 | input | 32 | Pulse command word 1 |
| cmd_word2 | input | 32 | Pulse command word 2 |
| out_i | output | 16 | Summed in-phase sample |
| out_q | output | 16 | Summed quadrature sample |

## Verification
The bound checker covers the following on every cycle: the output is zero on the cycle after reset, a location word with the profile-select bit cleared blocks the next write, the word pointer steps by one across back-to-back data writes, and the latched active settings do not move unless a command was sampled. The numeric path can only be shown by the bench's scenarios, which compare every sample against a cycle model of the phase, table, scaling and wrapping sum. That path includes absolute phase on reselection, the exact command field positions, the three-edge switch timing, and data writes that are ignored after a foreign location word.

// File: rtl/obank_pkg.sv
package obank_pkg;

    localparam int FTW_W     = 32;
    localparam int AMP_W     = 16;
    localparam int POW_W     = 16;
    localparam int SMP_W     = 16;
    localparam int CMD_W     = 32;
    localparam int WIN_AW    = 10;
    localparam int CMD_WORDS = 3;
    localparam int HOST_W    = 32;

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pw;
        logic [AMP_W-1:0] amp;
    } prof_t;

    localparam int PROF_BITS = $bits(prof_t);

    // Rational sine approximation over one half turn, mirrored for the other half.
    function automatic logic signed [SMP_W-1:0] sine_at(input int k, input int aw);
        longint hm, m, a, v;
        hm = longint'(1) << (aw - 1);
        m  = longint'(k) % hm;
        a  = m * (hm - m);
        v  = (longint'((1 << (SMP_W-1)) - 1) * 16 * a) / (5 * hm * hm - 4 * a);
        if (longint'(k) >= hm) v = -v;
        return SMP_W'(v);
    endfunction

    // Word index of oscillator i's slot field in the pulse command.
    function automatic int fld_word(input int i, input int aw);
        int pos, w;
        pos = WIN_AW;
        w   = 0;
        for (int j = 0; j <= i; j++) begin
            if (pos > CMD_W - aw) begin
                w++;
                pos = 0;
            end
            if (j != i) pos += aw;
        end
        return w;
    endfunction

    // Bit offset of oscillator i's slot field inside its word.
    function automatic int fld_bit(input int i, input int aw);
        int pos;
        pos = WIN_AW;
        for (int j = 0; j <= i; j++) begin
            if (pos > CMD_W - aw) pos = 0;
            if (j != i) pos += aw;
        end
        return pos;
    endfunction

endpackage

// File: rtl/obank_wr_decode.sv
module obank_wr_decode
    import obank_pkg::*;
#(
    parameter int PTR_W   = 10,
    parameter bit CHAN_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              wr_addr_sel,
    input  logic [HOST_W-1:0] wr_data,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_ptr
);
    localparam int CHAN_BIT = 15;
    localparam int SEL_BIT  = 14;

    typedef struct packed {
        logic             en;
        logic [PTR_W-1:0] ptr;
    } dec_t;

    dec_t dec_d, dec_q;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{wr_data[HOST_W-1:CHAN_BIT+1], wr_data[SEL_BIT-1:PTR_W]};

    always_comb begin
        dec_d  = dec_q;
        mem_we = 1'b0;
        if (wr_stb) begin
            if (wr_addr_sel) begin
                dec_d.en  = (wr_data[CHAN_BIT] == CHAN_ID) && wr_data[SEL_BIT];
                dec_d.ptr = wr_data[PTR_W-1:0];
            end else if (dec_q.en) begin
                mem_we    = 1'b1;
                dec_d.ptr = dec_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    assign mem_ptr = dec_q.ptr;

endmodule

// File: rtl/obank_prof_mem.sv
module obank_prof_mem
    import obank_pkg::*;
#(
    parameter int N_OSC   = 16,
    parameter int PROF_AW = 5
) (
    input  logic               clk,
    input  logic               we,
    input  logic [$clog2(N_OSC)+PROF_AW:0] wptr,
    input  logic [HOST_W-1:0]  wdata,
    input  logic [PROF_AW-1:0] rd_sel  [N_OSC],
    output prof_t              rd_prof [N_OSC]
);
    localparam int N_PROF = 1 << PROF_AW;
    localparam int DEPTH  = N_OSC * N_PROF;
    localparam int ROW_W  = $clog2(N_OSC) + PROF_AW;

    logic [HOST_W-1:0] ftw_m [DEPTH];
    logic [HOST_W-1:0] ap_m  [DEPTH];

    logic [ROW_W-1:0] wrow;
    assign wrow = wptr[ROW_W:1];

    // Plain storage: no reset, contents are defined by host writes.
    always_ff @(posedge clk) begin
        if (we) begin
            if (wptr[0]) ap_m[wrow]  <= wdata;
            else         ftw_m[wrow] <= wdata;
        end
    end

    for (genvar o = 0; o < N_OSC; o++) begin : g_rd
        logic [ROW_W-1:0] rrow;
        assign rrow = {ROW_W'(o) << PROF_AW} | ROW_W'(rd_sel[o]);
        assign rd_prof[o].ftw = ftw_m[rrow];
        assign rd_prof[o].pw  = ap_m[rrow][HOST_W-1:AMP_W];
        assign rd_prof[o].amp = ap_m[rrow][AMP_W-1:0];
    end

endmodule

// File: rtl/obank_osc.sv
module obank_osc
    import obank_pkg::*;
#(
    parameter int SIN_AW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  prof_t                   prof_in,
    input  logic [FTW_W-1:0]        n,
    input  logic signed [SMP_W-1:0] sin_tab [1 << SIN_AW],
    output logic signed [SMP_W-1:0] i_o,
    output logic signed [SMP_W-1:0] q_o,
    output prof_t                   act_o
);
    localparam logic [SIN_AW-1:0] QTR = SIN_AW'(1 << (SIN_AW - 2));

    typedef struct packed {
        prof_t                   act;
        logic [SIN_AW-1:0]       idx;
        logic [AMP_W-1:0]        amp;
        logic signed [SMP_W-1:0] si;
        logic signed [SMP_W-1:0] sq;
    } osc_t;

    osc_t osc_d, osc_q;

    function automatic logic signed [SMP_W-1:0] scale(
        input logic signed [SMP_W-1:0] v,
        input logic [AMP_W-1:0]        a
    );
        logic signed [SMP_W+AMP_W:0] p;
        p = v * $signed({1'b0, a});
        return SMP_W'(p >>> AMP_W);
    endfunction

    logic [FTW_W-1:0]  ph;
    logic [SIN_AW-1:0] cos_idx;

    always_comb begin
        osc_d = osc_q;
        if (load) osc_d.act = prof_in;
        // stage 1: absolute phase from the sample count
        ph        = n * osc_q.act.ftw + {osc_q.act.pw, {(FTW_W-POW_W){1'b0}}};
        osc_d.idx = SIN_AW'(ph >> (FTW_W - SIN_AW));
        osc_d.amp = osc_q.act.amp;
        // stage 2: table lookup and amplitude scaling
        cos_idx   = osc_q.idx + QTR;
        osc_d.si  = scale(sin_tab[cos_idx], osc_q.amp);
        osc_d.sq  = scale(sin_tab[osc_q.idx], osc_q.amp);
    end

    always_ff @(posedge clk) begin
        if (rst) osc_q <= '0;
        else     osc_q <= osc_d;
    end

    assign i_o   = osc_q.si;
    assign q_o   = osc_q.sq;
    assign act_o = osc_q.act;

endmodule

// File: rtl/obank_top.sv
module obank_top
    import obank_pkg::*;
#(
    parameter int N_OSC   = 16,
    parameter int PROF_AW = 5,
    parameter int SIN_AW  = 8,
    parameter bit CHAN_ID = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_stb,
    input  logic                    wr_addr_sel,
    input  logic [HOST_W-1:0]       wr_data,
    input  logic                    cmd_stb,
    input  logic [CMD_W-1:0]        cmd_word0,
    input  logic [CMD_W-1:0]        cmd_word1,
    input  logic [CMD_W-1:0]        cmd_word2,
    output logic signed [SMP_W-1:0] out_i,
    output logic signed [SMP_W-1:0] out_q
);
    localparam int OSC_AW  = $clog2(N_OSC);
    localparam int PTR_W   = OSC_AW + PROF_AW + 1;
    localparam int ACT_W   = N_OSC * PROF_BITS;
    localparam int TAB_N   = 1 << SIN_AW;

    typedef struct packed {
        logic [FTW_W-1:0]        n;
        logic signed [SMP_W-1:0] si;
        logic signed [SMP_W-1:0] sq;
    } top_t;

    top_t top_d, top_q;

    logic                    mem_we;
    logic [PTR_W-1:0]        mem_ptr;
    logic [PROF_AW-1:0]      sel     [N_OSC];
    prof_t                   rd_prof [N_OSC];
    prof_t                   act_w   [N_OSC];
    logic signed [SMP_W-1:0] osc_i   [N_OSC];
    logic signed [SMP_W-1:0] osc_q   [N_OSC];
    logic signed [SMP_W-1:0] sin_tab [TAB_N];
    logic [ACT_W-1:0]        act_flat;
    logic [CMD_WORDS*CMD_W-1:0] cmd_all;
    logic                    unused_cmd_bits;

    assign cmd_all         = {cmd_word2, cmd_word1, cmd_word0};
    assign unused_cmd_bits = ^cmd_all;

    for (genvar k = 0; k < TAB_N; k++) begin : g_tab
        assign sin_tab[k] = sine_at(k, SIN_AW);
    end

    obank_wr_decode #(.PTR_W(PTR_W), .CHAN_ID(CHAN_ID)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_addr_sel(wr_addr_sel),
        .wr_data    (wr_data),
        .mem_we     (mem_we),
        .mem_ptr    (mem_ptr)
    );

    obank_prof_mem #(.N_OSC(N_OSC), .PROF_AW(PROF_AW)) u_mem (
        .clk    (clk),
        .we     (mem_we),
        .wptr   (mem_ptr),
        .wdata  (wr_data),
        .rd_sel (sel),
        .rd_prof(rd_prof)
    );

    for (genvar o = 0; o < N_OSC; o++) begin : g_osc
        localparam int FW = fld_word(o, PROF_AW);
        localparam int FB = fld_bit(o, PROF_AW);
        assign sel[o] = cmd_all[FW*CMD_W + FB +: PROF_AW];

        obank_osc #(.SIN_AW(SIN_AW)) u_osc (
            .clk    (clk),
            .rst    (rst),
            .load   (cmd_stb),
            .prof_in(rd_prof[o]),
            .n      (top_q.n),
            .sin_tab(sin_tab),
            .i_o    (osc_i[o]),
            .q_o    (osc_q[o]),
            .act_o  (act_w[o])
        );

        assign act_flat[o*PROF_BITS +: PROF_BITS] = act_w[o];
    end

    logic signed [SMP_W-1:0] acc_i, acc_q;

    always_comb begin
        top_d = top_q;
        acc_i = '0;
        acc_q = '0;
        for (int o = 0; o < N_OSC; o++) begin
            acc_i = acc_i + osc_i[o];
            acc_q = acc_q + osc_q[o];
        end
        top_d.n  = top_q.n + 1'b1;
        top_d.si = acc_i;
        top_d.sq = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign out_i = top_q.si;
    assign out_q = top_q.sq;

endmodule

// File: rtl/obank_chk.sv
module obank_chk #(
    parameter int PTR_W = 10,
    parameter int ACT_W = 1024
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_stb,
    input logic               wr_addr_sel,
    input logic [31:0]        wr_data,
    input logic               cmd_stb,
    input logic signed [15:0] out_i,
    input logic signed [15:0] out_q,
    input logic               mem_we,
    input logic [PTR_W-1:0]   mem_ptr,
    input logic [ACT_W-1:0]   act_flat
);

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_i == 16'sd0 && out_q == 16'sd0));

    assert_foreign_loc_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr_sel && !wr_data[14]) |=> !mem_we);

    assert_ptr_steps_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_ptr == $past(mem_ptr) + 1'b1));

    assert_active_held_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_stb) |-> $stable(act_flat));

endmodule

bind obank_top obank_chk #(.PTR_W(PTR_W), .ACT_W(ACT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_addr_sel(wr_addr_sel),
    .wr_data    (wr_data),
    .cmd_stb    (cmd_stb),
    .out_i      (out_i),
    .out_q      (out_q),
    .mem_we     (mem_we),
    .mem_ptr    (mem_ptr),
    .act_flat   (act_flat)
);

// File: tb/obank_top_tb_top.sv
module obank_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_stb, wr_addr_sel;
    logic [31:0] wr_data;
    logic        cmd_stb;
    logic [31:0] cmd_word0, cmd_word1, cmd_word2;
    logic signed [15:0] out_i, out_q;

    always #5 clk = ~clk;

    obank_top dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr_sel(wr_addr_sel),
        .wr_data(wr_data), .cmd_stb(cmd_stb), .cmd_word0(cmd_word0),
        .cmd_word1(cmd_word1), .cmd_word2(cmd_word2), .out_i(out_i), .out_q(out_q)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    // host-side model state
    logic [31:0] ftw_m [1024];
    logic [31:0] ap_m  [1024];
    bit          m_en;
    logic [9:0]  m_ptr;
    logic [4:0]  pend  [16];
    logic [31:0] a_ftw [16];
    logic [31:0] a_ap  [16];
    logic [31:0] n_m;
    logic [15:0] ei [3];
    logic [15:0] eq [3];
    int          pushes = 0;

    // R8 sine table formula
    function automatic int sin_ref(input int k);
        longint m, a, v;
        m = k % 128;
        a = m * (128 - m);
        v = (longint'(32767) * 16 * a) / (81920 - 4 * a);
        return (k >= 128) ? -int'(v) : int'(v);
    endfunction

    // R7 R9 R10 expected output sample
    function automatic logic [31:0] model_out(input logic [31:0] n);
        longint si, sq;
        si = 0;
        sq = 0;
        for (int o = 0; o < 16; o++) begin
            logic [31:0] ph;
            int idx, c, s;
            longint amp;
            ph  = n * a_ftw[o] + {a_ap[o][31:16], 16'h0000};
            idx = int'(ph[31:24]);
            c   = sin_ref((idx + 64) % 256);
            s   = sin_ref(idx);
            amp = longint'(a_ap[o][15:0]);
            si  = si + ((longint'(c) * amp) >>> 16);
            sq  = sq + ((longint'(s) * amp) >>> 16);
        end
        return {si[15:0], sq[15:0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            n_m = 0;
            for (int o = 0; o < 16; o++) begin a_ftw[o] = 0; a_ap[o] = 0; end
        end else begin
            n_m = n_m + 1;
            if (cmd_stb) begin
                for (int o = 0; o < 16; o++) begin
                    a_ftw[o] = ftw_m[o*64 + int'(pend[o])*2];
                    a_ap[o]  = ap_m[o*64 + int'(pend[o])*2 + 1];
                end
            end
        end
    end

    // continuous sample comparison: new selection visible three edges later (R6)
    always @(negedge clk) begin
        if (rst) begin
            pushes = 0;
        end else if (!done) begin
            logic [31:0] e;
            if (pushes >= 3) begin
                checks++;
                if (out_i !== ei[2] || out_q !== eq[2]) begin
                    fails++;
                    $display("FAIL %s (R6 R7 R8 R9 R10 sample) n=%0d actual i=%0d q=%0d expected i=%0d q=%0d",
                             cur_tag, n_m, out_i, out_q, $signed(ei[2]), $signed(eq[2]));
                end
            end
            ei[2] = ei[1]; eq[2] = eq[1];
            ei[1] = ei[0]; eq[1] = eq[0];
            e = model_out(n_m);
            ei[0] = e[31:16];
            eq[0] = e[15:0];
            pushes++;
        end
    end

    function automatic logic [31:0] loc_word(input bit ch, input bit psel,
                                             input int o, input int p, input bit w);
        return (32'(ch) << 15) | (32'(psel) << 14) | (32'(o) << 6) | (32'(p) << 1) | 32'(w);
    endfunction

    task automatic put_loc(input logic [31:0] w);
        wr_stb = 1'b1; wr_addr_sel = 1'b1; wr_data = w;
        m_en  = (w[15] == 1'b0) && w[14];
        m_ptr = w[9:0];
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic put_data(input logic [31:0] d);
        wr_stb = 1'b1; wr_addr_sel = 1'b0; wr_data = d;
        if (m_en) begin
            if (m_ptr[0]) ap_m[m_ptr] = d;
            else          ftw_m[m_ptr] = d;
            m_ptr = m_ptr + 10'd1;
        end
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic put_prof(input int o, input int p, input logic [31:0] ftw,
                            input logic [15:0] amp, input logic [15:0] pw);
        put_loc(loc_word(1'b0, 1'b1, o, p, 1'b0));
        put_data(ftw);
        put_data({pw, amp});
    endtask

    // R5 packing written from the field layout
    task automatic send_cmd(input logic [4:0] s [16], input logic [9:0] win);
        logic [31:0] w [3];
        int wi, pos;
        w[0] = {22'h0, win}; w[1] = 0; w[2] = 0;
        wi = 0; pos = 10;
        for (int o = 0; o < 16; o++) begin
            if (pos > 27) begin wi++; pos = 0; end
            w[wi] = w[wi] | (32'(s[o]) << pos);
            pos += 5;
        end
        for (int o = 0; o < 16; o++) pend[o] = s[o];
        cmd_word0 = w[0]; cmd_word1 = w[1]; cmd_word2 = w[2];
        cmd_stb = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [4:0] s [16];
        void'($urandom(32'd20231));
        rst = 1'b1; wr_stb = 0; wr_addr_sel = 0; wr_data = 0;
        cmd_stb = 0; cmd_word0 = 0; cmd_word1 = 0; cmd_word2 = 0;
        m_en = 0; m_ptr = 0;
        for (int o = 0; o < 16; o++) pend[o] = 0;

        // R1: outputs held at zero in reset
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (out_i !== 16'sd0 || out_q !== 16'sd0) begin
                fails++;
                $display("FAIL R1 reset output actual i=%0d q=%0d expected 0 0", out_i, out_q);
            end
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_i !== 16'sd0 || out_q !== 16'sd0) begin
            fails++;
            $display("FAIL R1 first sample after reset actual i=%0d q=%0d expected 0 0", out_i, out_q);
        end

        // R3 R4: stream the whole memory from one location word
        cur_tag = "R3 R4 stream fill";
        put_loc(loc_word(1'b0, 1'b1, 0, 0, 1'b0));
        for (int k = 0; k < 1024; k++) begin
            if (k[0] == 1'b0) put_data($urandom);
            else if (((k >> 1) % 32) == 0) put_data({16'($urandom), 16'h0000});
            else put_data({16'($urandom), 16'($urandom & 32'h0fff)});
        end
        for (int r = 0; r < 6; r++) begin
            for (int o = 0; o < 16; o++) s[o] = 5'($urandom);
            send_cmd(s, 10'($urandom));
            idle(6);
        end

        // R3: start on the amplitude word, roll into the next slot's tuning word
        cur_tag = "R3 mid-slot start";
        put_loc(loc_word(1'b0, 1'b1, 2, 9, 1'b1));
        put_data({16'h3000, 16'h2222});
        put_data(32'h0123_4567);
        for (int o = 0; o < 16; o++) s[o] = 0;
        s[2] = 9;  send_cmd(s, 0); idle(6);
        s[2] = 10; send_cmd(s, 0); idle(6);

        // R2: foreign channel and non-profile location words block data
        cur_tag = "R2 blocked writes";
        put_prof(5, 20, 32'h0200_0000, 16'h8000, 16'h1000);
        put_loc(loc_word(1'b1, 1'b1, 5, 20, 1'b0));
        put_data(32'h7777_0000); put_data({16'h0000, 16'hffff});
        put_loc(loc_word(1'b0, 1'b0, 5, 20, 1'b0));
        put_data(32'h1111_0000); put_data({16'h4000, 16'h1234});
        for (int o = 0; o < 16; o++) s[o] = 0;
        s[5] = 20; send_cmd(s, 0); idle(10);

        // R5: only the field in word 2 for oscillator 12 selects a live slot
        cur_tag = "R5 word2 field";
        put_prof(12, 17, 32'h0100_0000, 16'hc000, 16'h0000);
        for (int o = 0; o < 16; o++) s[o] = 0;
        s[12] = 17; send_cmd(s, 10'h3ff); idle(10);

        // R8 R9: static phases, exact table points and scaling
        cur_tag = "R8 R9 static phase";
        put_prof(0, 3, 32'h0, 16'hffff, 16'h4000);
        put_prof(1, 3, 32'h0, 16'h1234, 16'h2000);
        for (int o = 0; o < 16; o++) s[o] = 0;
        s[0] = 3; s[1] = 3; send_cmd(s, 0); idle(8);

        // R10: full-scale sum of sixteen oscillators wraps
        cur_tag = "R10 wrap";
        for (int o = 0; o < 16; o++) put_prof(o, 31, 32'h0, 16'hffff, 16'h0000);
        for (int o = 0; o < 16; o++) s[o] = 31;
        send_cmd(s, 0); idle(8);

        // R7: leave and return to a slot, phase stays absolute
        cur_tag = "R7 reselect";
        put_prof(3, 4, 32'h0137_0000, 16'h7000, 16'h0800);
        put_prof(3, 5, 32'hf900_0000, 16'h7000, 16'h9000);
        for (int o = 0; o < 16; o++) s[o] = 0;
        s[3] = 4; send_cmd(s, 0); idle(13);
        s[3] = 5; send_cmd(s, 0); idle(7);
        s[3] = 4; send_cmd(s, 0); idle(11);

        // R11: rewriting the active slot leaves the output on the old values
        cur_tag = "R11 write while active";
        put_prof(3, 4, 32'h0000_0000, 16'h0000, 16'h0000);
        a_ftw[3] = a_ftw[3];
        idle(12);
        s[3] = 4; send_cmd(s, 0); idle(6);

        // R6: random commands, some back to back
        cur_tag = "R6 random bursts";
        for (int r = 0; r < 300; r++) begin
            for (int o = 0; o < 16; o++) s[o] = 5'($urandom);
            send_cmd(s, 10'($urandom));
            idle(int'($urandom % 4));
        end
        idle(5);

        done = 1'b1;
        report();
        $finish;
    end

endmodule